// File: doc/BRIEF.md
# Dual-Port PS/2 Host Controller

This block is a PS/2 host that serves two device ports with a single receiver and a single transmitter. Both the clock and the data line of each port pass through a synchroniser and a stability filter whose window is picked at run time. Either a short or a long window can be chosen. The receiver listens on every enabled port. It locks onto the first port that shows a start bit, assembles the frame, and tags the stored byte with the port it came from.

Firmware chooses a transmit port and then writes a byte to the data register. The block holds that port's clock low to inhibit the device, issues a request-to-send, and shifts out the data, odd parity and stop bit on the device's clock edges. It then checks the acknowledge bit. Four events are latched into write-1-to-clear pending flags, and each flag is masked by its own enable before it reaches one interrupt line. These events are byte received, byte sent, transmit timeout and parity error. A receive timeout flag and force-idle strobes for the receiver and the transmitter complete the control set. The pads are modelled as an input level and an active-high pull-low enable for each line.

Top module: `ps2_dual_host`

Register map (3-bit address, 8-bit data, reads combinational):
- 0 config: [0] received-byte enable, [1] sent-byte enable, [2] tx-timeout enable, [3] parity-error enable, [5] port 1 enable, [6] port 2 enable.
- 1 pending: [0] received, [1] sent, [2] tx timeout, [3] parity error (write 1 to clear); [5] last byte from port 1, [6] last byte from port 2 (read only).
- 2 control: [0] transmit port (0 = port 1, 1 = port 2); [1] receive timeout flag (write 1 to clear); [2] write 1 to force the receiver idle; [3] write 1 to force the transmitter idle.
- 3 data: a read returns the last received byte, and a write starts a transmit.
- 4 filter: [0] 0 = short window, 1 = long window.
- 5 pin levels and 6 driven levels: [0] clock 1, [1] data 1, [2] clock 2, [3] data 2 (1 = high or released).

## Requirements
- R1: After reset the config, pending, control, data and filter registers read 0, the pin-level and driven-level registers read 0x0F, no pad is pulled low and the interrupt is low.
- R2: A frame on an enabled port is received, with start 0, eight data bits LSB first, odd parity and stop 1, each bit sampled at a filtered falling clock edge. The byte becomes readable at address 3 and pending bit 0 sets.
- R3: Pending bit 5 or bit 6 (never both) marks whether the last byte came from port 1 or port 2. A frame on a port whose enable (config bit 5 or 6) is 0 is ignored.
- R4: A frame whose parity is not odd still stores its byte and sets pending bit 3 as well as bit 0.
- R5: A write to address 3 pulls the selected port's clock low for at least INHIBIT_CYC cycles. It then pulls data low with the clock released. Data bits LSB first, odd parity and a released stop bit follow, one per device falling edge. A low acknowledge at the eleventh edge sets pending bit 1. The other port is never driven.
- R6: With no device edge within START_TMO cycles of the request, or no finished frame within FINISH_TMO cycles of the first edge, the transmit aborts. Pending bit 2 sets and every pad is released.
- R7: A high acknowledge bit ends the transmit with pending bit 2 set and bit 1 clear.
- R8: A frame that shows no clock edge for RX_TMO cycles is dropped and control bit 1 sets. The next frame is then received correctly.
- R9: Writing control bit 2 returns a partly received frame to idle, so the next frame is assembled from its own start bit. Writing control bit 3 releases the pads at once and no timeout follows.
- R10: A line level reaches the pin-level register only once it has been stable for DEB_SHORT cycles (filter bit 0 = 0) or DEB_LONG cycles (filter bit 0 = 1). Shorter pulses are filtered out.
- R11: Pending bits 0 to 3 clear when 1 is written to them. The interrupt is high exactly when some pending bit 0 to 3 has its config enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irq | output | 1 | Interrupt, OR of enabled pending flags |
| ps2ClkIn | input | 2 | Clock pad level, port 1 in bit 0 |
| ps2DatIn | input | 2 | Data pad level, port 1 in bit 0 |
| ps2ClkOe | output | 2 | Pull clock pad low |
| ps2DatOe | output | 2 | Pull data pad low |

## Verification
Reception is driven with correct and wrong parity, on each port, on a disabled port, and as truncated frames. These tell apart byte assembly, parity flagging, port tagging, port masking and recovery through the timeout or the forced reset. Transmission runs against a device model that decodes the shifted bits. The model either acknowledges, withholds the acknowledge, stops clocking part way or never clocks, so a good completion is separated from each failure path and from the forced idle. Data-line pulses of varied length against both filter windows show which widths pass the filter.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
  localparam int NPORT = 2;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_PEND = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_FILT = 3'd4;
  localparam logic [2:0] A_PINS = 3'd5;
  localparam logic [2:0] A_PINO = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_TX_INH, S_TX_REQ, S_TX_BITS} ctlState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic rxShift;
    logic rxDone;
    logic rxAbort;
    logic txShift;
    logic txOk;
    logic txTmo;
    logic holdClk;
    logic driveTx;
    logic port;
  } ps2Strb_t;
endpackage

// File: rtl/ps2_dual_dp.sv
module ps2_dual_dp
  import ps2_pkg::*;
#(
  parameter int DEB_SHORT = 100,
  parameter int DEB_LONG  = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             irq,
  input  logic [NPORT-1:0] ps2ClkIn,
  input  logic [NPORT-1:0] ps2DatIn,
  output logic [NPORT-1:0] ps2ClkOe,
  output logic [NPORT-1:0] ps2DatOe,
  input  ps2Strb_t         strb,
  output logic [NPORT-1:0] fall,
  output logic [NPORT-1:0] datLvl,
  output logic [NPORT-1:0] portEn,
  output logic             txPort,
  output logic             startTx,
  output logic             rxRst,
  output logic             txRst
);
  localparam int DW    = $clog2(DEB_LONG + 1);
  localparam int NLINE = 2 * NPORT;

  logic [NLINE-1:0] rawLvl, pinLvl, pinOut;
  logic [NPORT-1:0] clkLvl, clkPrev;
  logic [DW-1:0]    debLim;
  logic [6:0]       cfg;
  logic [3:0]       pend, pendSet, pendClr;
  logic [1:0]       tag;
  logic             rxTo, longDeb;
  logic [7:0]       rxData;
  logic [8:0]       rxSh;
  logic [10:0]      txSh;

  always_comb debLim = longDeb ? DW'(DEB_LONG - 1) : DW'(DEB_SHORT - 1);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign rawLvl[2*p]   = ps2ClkIn[p];
    assign rawLvl[2*p+1] = ps2DatIn[p];
    assign clkLvl[p]     = pinLvl[2*p];
    assign datLvl[p]     = pinLvl[2*p+1];
    assign fall[p]       = clkPrev[p] & ~clkLvl[p];
    assign portEn[p]     = cfg[5+p];
    assign ps2ClkOe[p]   = strb.holdClk && (strb.port == 1'(p));
    assign ps2DatOe[p]   = strb.driveTx && (strb.port == 1'(p)) && !txSh[0];
    assign pinOut[2*p]   = ~ps2ClkOe[p];
    assign pinOut[2*p+1] = ~ps2DatOe[p];
  end

  // per-line synchroniser and stability filter
  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    logic [1:0]    syn;
    logic [DW-1:0] cnt;
    logic          filt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syn <= 2'b11; cnt <= '0; filt <= 1'b1;
      end else begin
        syn <= {syn[0], rawLvl[g]};
        if (syn[1] == filt) cnt <= '0;
        else if (cnt >= debLim) begin
          filt <= syn[1];
          cnt  <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign pinLvl[g] = filt;
  end

  assign startTx = regWr && regAddr == A_DATA;
  assign rxRst   = regWr && regAddr == A_CTRL && regWdata[2];
  assign txRst   = regWr && regAddr == A_CTRL && regWdata[3];
  assign pendClr = (regWr && regAddr == A_PEND) ? regWdata[3:0] : 4'b0;
  assign pendSet = {strb.rxDone && !(^rxSh), strb.txTmo, strb.txOk, strb.rxDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0; pend <= '0; tag <= '0; rxTo <= 1'b0; longDeb <= 1'b0; txPort <= 1'b0;
      rxData <= '0; rxSh <= '0; txSh <= '1; clkPrev <= '1;
    end else begin
      clkPrev <= clkLvl;
      if (regWr && regAddr == A_CFG)  cfg <= {regWdata[6:5], 1'b0, regWdata[3:0]};
      if (regWr && regAddr == A_CTRL) txPort <= regWdata[0];
      if (regWr && regAddr == A_FILT) longDeb <= regWdata[0];
      pend <= (pend & ~pendClr) | pendSet;
      if (strb.rxAbort) rxTo <= 1'b1;
      else if (regWr && regAddr == A_CTRL && regWdata[1]) rxTo <= 1'b0;
      if (strb.rxShift) rxSh <= {datLvl[strb.port], rxSh[8:1]};
      if (strb.rxDone) begin
        rxData <= rxSh[7:0];
        tag    <= strb.port ? 2'b10 : 2'b01;
      end
      if (startTx) txSh <= {1'b1, ~^regWdata, regWdata, 1'b0};
      else if (strb.txShift) txSh <= {1'b1, txSh[10:1]};
    end
  end

  always_comb begin
    case (regAddr)
      A_CFG:   regRdata = {1'b0, cfg};
      A_PEND:  regRdata = {1'b0, tag, 1'b0, pend};
      A_CTRL:  regRdata = {6'b0, rxTo, txPort};
      A_DATA:  regRdata = rxData;
      A_FILT:  regRdata = {7'b0, longDeb};
      A_PINS:  regRdata = {4'b0, pinLvl};
      A_PINO:  regRdata = {4'b0, pinOut};
      default: regRdata = 8'h00;
    endcase
  end

  assign irq = |(pend & cfg[3:0]);

  AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(tag)); // R3
  AST_RX_FLAG_SRC: assert property (@(posedge clk) disable iff (!rstN) $rose(pend[0]) |-> $past(strb.rxDone)); // R2
  AST_PAR_FLAG_SRC: assert property (@(posedge clk) disable iff (!rstN) $rose(pend[3]) |-> $past(strb.rxDone)); // R4
  AST_TX_FLAG_SRC: assert property (@(posedge clk) disable iff (!rstN) $rose(pend[1]) |-> $past(strb.txOk)); // R5
  AST_ONE_CLK_HOLD: assert property (@(posedge clk) disable iff (!rstN) !(&ps2ClkOe)); // R5
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rstN) strb.rxShift |-> (ps2ClkOe == '0 && ps2DatOe == '0)); // R2
endmodule

// File: rtl/ps2_dual_ctl.sv
module ps2_dual_ctl
  import ps2_pkg::*;
#(
  parameter int INHIBIT_CYC = 10000,
  parameter int START_TMO   = 1500000,
  parameter int FINISH_TMO  = 200000,
  parameter int RX_TMO      = 200000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPORT-1:0] fall,
  input  logic [NPORT-1:0] datLvl,
  input  logic [NPORT-1:0] portEn,
  input  logic             txPort,
  input  logic             startTx,
  input  logic             rxRst,
  input  logic             txRst,
  output ps2Strb_t         strb
);
  localparam int M1   = (INHIBIT_CYC > START_TMO) ? INHIBIT_CYC : START_TMO;
  localparam int M2   = (FINISH_TMO > RX_TMO) ? FINISH_TMO : RX_TMO;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] INH_L = TW'(INHIBIT_CYC - 1);
  localparam logic [TW-1:0] STA_L = TW'(START_TMO - 1);
  localparam logic [TW-1:0] FIN_L = TW'(FINISH_TMO - 1);
  localparam logic [TW-1:0] RXT_L = TW'(RX_TMO - 1);

  ctlState_t     state;
  logic          port, edgeHit, inTx;
  logic [3:0]    bitCnt;
  logic [TW-1:0] tmr;

  assign edgeHit = fall[port];
  assign inTx    = state == S_TX_INH || state == S_TX_REQ || state == S_TX_BITS;

  always_comb begin
    strb         = '0;
    strb.port    = port;
    strb.holdClk = state == S_TX_INH;
    strb.driveTx = state == S_TX_REQ || state == S_TX_BITS;
    case (state)
      S_RX: begin
        if (edgeHit) begin
          if (bitCnt == 4'd9) strb.rxDone = 1'b1;
          else strb.rxShift = 1'b1;
        end else if (tmr == RXT_L) strb.rxAbort = 1'b1;
      end
      S_TX_REQ: begin
        if (edgeHit) strb.txShift = 1'b1;
        else if (tmr == STA_L) strb.txTmo = 1'b1;
      end
      S_TX_BITS: begin
        if (edgeHit) begin
          if (bitCnt == 4'd10) begin
            strb.txOk  = !datLvl[port];
            strb.txTmo = datLvl[port];
          end else strb.txShift = 1'b1;
        end else if (tmr == FIN_L) strb.txTmo = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; port <= 1'b0; bitCnt <= '0; tmr <= '0;
    end else if (startTx) begin
      state <= S_TX_INH; port <= txPort; bitCnt <= '0; tmr <= '0;
    end else if ((txRst && inTx) || (rxRst && state == S_RX)) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          bitCnt <= '0;
          tmr    <= '0;
          if (fall[0] && portEn[0] && !datLvl[0]) begin
            state <= S_RX; port <= 1'b0;
          end else if (fall[1] && portEn[1] && !datLvl[1]) begin
            state <= S_RX; port <= 1'b1;
          end
        end
        S_RX: begin
          if (edgeHit) begin
            tmr <= '0;
            if (bitCnt == 4'd9) state <= S_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end else if (tmr == RXT_L) state <= S_IDLE;
          else tmr <= tmr + 1'b1;
        end
        S_TX_INH: begin
          if (tmr == INH_L) begin
            state <= S_TX_REQ; tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_TX_REQ: begin
          if (edgeHit) begin
            state <= S_TX_BITS; bitCnt <= 4'd1; tmr <= '0;
          end else if (tmr == STA_L) state <= S_IDLE;
          else tmr <= tmr + 1'b1;
        end
        S_TX_BITS: begin
          if (edgeHit) begin
            if (bitCnt == 4'd10) state <= S_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end else if (tmr == FIN_L) state <= S_IDLE;
          else tmr <= tmr + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_TMO_IN_TX: assert property (@(posedge clk) disable iff (!rstN) strb.txTmo |-> $past(startTx) == 1'b0 && (state == S_TX_REQ || state == S_TX_BITS)); // R6
  AST_RXTO_IN_RX: assert property (@(posedge clk) disable iff (!rstN) strb.rxAbort |-> state == S_RX && !edgeHit); // R8
  AST_INH_DONE: assert property (@(posedge clk) disable iff (!rstN) (state == S_TX_REQ && $past(state) == S_TX_INH) |-> $past(tmr) == INH_L); // R5
endmodule

// File: rtl/ps2_dual_host.sv
module ps2_dual_host
  import ps2_pkg::*;
#(
  parameter int DEB_SHORT   = 100,
  parameter int DEB_LONG    = 200,
  parameter int INHIBIT_CYC = 10000,
  parameter int START_TMO   = 1500000,
  parameter int FINISH_TMO  = 200000,
  parameter int RX_TMO      = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic [1:0] ps2ClkIn,
  input  logic [1:0] ps2DatIn,
  output logic [1:0] ps2ClkOe,
  output logic [1:0] ps2DatOe
);
  ps2Strb_t         strb;
  logic [NPORT-1:0] fall, datLvl, portEn;
  logic             txPort, startTx, rxRst, txRst;

  ps2_dual_dp #(.DEB_SHORT(DEB_SHORT), .DEB_LONG(DEB_LONG)) i_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .ps2ClkIn(ps2ClkIn), .ps2DatIn(ps2DatIn),
    .ps2ClkOe(ps2ClkOe), .ps2DatOe(ps2DatOe), .strb(strb), .fall(fall),
    .datLvl(datLvl), .portEn(portEn), .txPort(txPort), .startTx(startTx),
    .rxRst(rxRst), .txRst(txRst)
  );

  ps2_dual_ctl #(.INHIBIT_CYC(INHIBIT_CYC), .START_TMO(START_TMO),
                 .FINISH_TMO(FINISH_TMO), .RX_TMO(RX_TMO)) i_ctl (
    .clk(clk), .rstN(rstN), .fall(fall), .datLvl(datLvl), .portEn(portEn),
    .txPort(txPort), .startTx(startTx), .rxRst(rxRst), .txRst(txRst), .strb(strb)
  );
endmodule

// File: tb/test_ps2_dual_host.sv
`timescale 1ns/1ps
module test_ps2_dual_host;
  localparam int DS = 4, DL = 8, INH = 50, STO = 2000, FTO = 3000, RTO = 1500;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq;
  logic [1:0] devClk = 2'b11;
  logic [1:0] devDat = 2'b11;
  logic [1:0] ps2ClkOe, ps2DatOe;
  logic [1:0] ps2ClkIn, ps2DatIn;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign ps2ClkIn = devClk & ~ps2ClkOe;
  assign ps2DatIn = devDat & ~ps2DatOe;

  always #2.5 clk = ~clk;

  ps2_dual_host #(.DEB_SHORT(DS), .DEB_LONG(DL), .INHIBIT_CYC(INH), .START_TMO(STO),
                  .FINISH_TMO(FTO), .RX_TMO(RTO)) i_ps2_dual_host (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .ps2ClkIn(ps2ClkIn), .ps2DatIn(ps2DatIn),
    .ps2ClkOe(ps2ClkOe), .ps2DatOe(ps2DatOe)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // device sends the first n bits of a frame on port p
  task automatic sendFrame(input int p, input logic [7:0] d, input bit badPar, input int n);
    logic [10:0] fr;
    fr = {1'b1, (~^d) ^ badPar, d, 1'b0};
    for (int i = 0; i < n; i++) begin
      devDat[p] = fr[i];
      cyc(15);
      devClk[p] = 1'b0;
      cyc(30);
      devClk[p] = 1'b1;
      cyc(15);
    end
    devDat[p] = 1'b1;
    cyc(20);
  endtask

  // device receives on port p: nclk clocks, ack edge when nclk > 10
  task automatic devRecv(input int p, input bit ackLow, input int nclk,
                         output logic [9:0] got, output int inh);
    got = '0;
    inh = 0;
    while (!ps2ClkOe[p]) cyc(1);
    while (ps2ClkOe[p]) begin inh++; cyc(1); end
    while (!ps2DatOe[p]) cyc(1);
    cyc(20);
    for (int i = 0; i < nclk && i < 10; i++) begin
      devClk[p] = 1'b0;
      cyc(30);
      got[i] = devDat[p] & ~ps2DatOe[p];
      devClk[p] = 1'b1;
      cyc(30);
    end
    if (nclk > 10) begin
      devDat[p] = ackLow ? 1'b0 : 1'b1;
      cyc(15);
      devClk[p] = 1'b0;
      cyc(30);
      devClk[p] = 1'b1;
      cyc(15);
      devDat[p] = 1'b1;
    end
    cyc(20);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd0, v); chk("R1 cfg", v, 8'h00);
    rd(3'd1, v); chk("R1 pend", v, 8'h00);
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd3, v); chk("R1 data", v, 8'h00);
    rd(3'd4, v); chk("R1 filt", v, 8'h00);
    rd(3'd5, v); chk("R1 pins", v, 8'h0F);
    rd(3'd6, v); chk("R1 pino", v, 8'h0F);
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", {ps2ClkOe, ps2DatOe}, 4'h0);
  endtask

  task automatic t_rx_port1;
    logic [7:0] v;
    wr(3'd0, 8'h6F);
    sendFrame(0, 8'hA5, 0, 11);
    rd(3'd3, v); chk("R2 rx byte", v, 8'hA5);
    rd(3'd1, v); chk("R2 R3 pend+tag port1", v, 8'h21);
    chk("R11 irq set", irq, 1'b1);
    wr(3'd0, 8'h6E);
    #1 chk("R11 irq masked", irq, 1'b0);
    rd(3'd1, v); chk("R11 pend kept under mask", v[3:0], 4'h1);
    wr(3'd0, 8'h6F);
    #1 chk("R11 irq unmasked", irq, 1'b1);
    wr(3'd1, 8'h01);
    rd(3'd1, v); chk("R11 w1c", v, 8'h20);
    chk("R11 irq cleared", irq, 1'b0);
  endtask

  task automatic t_rx_port2_par;
    logic [7:0] v;
    sendFrame(1, 8'h3C, 1, 11);
    rd(3'd3, v); chk("R4 byte kept", v, 8'h3C);
    rd(3'd1, v); chk("R4 R3 parity+tag port2", v, 8'h49);
    wr(3'd1, 8'h0F);
    rd(3'd1, v); chk("R11 w1c multi", v[3:0], 4'h0);
  endtask

  task automatic t_rx_disabled;
    logic [7:0] v;
    wr(3'd0, 8'h2F);
    sendFrame(1, 8'h11, 0, 11);
    rd(3'd1, v); chk("R3 disabled port no event", v[3:0], 4'h0);
    rd(3'd3, v); chk("R3 disabled port data kept", v, 8'h3C);
    wr(3'd0, 8'h6F);
  endtask

  task automatic t_tx_ok;
    logic [7:0] v;
    logic [9:0] got;
    int inh;
    bit p1drv;
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h5A);
    p1drv = 0;
    fork
      devRecv(1, 1, 11, got, inh);
      repeat (1200) begin @(negedge clk); if (ps2ClkOe[0] || ps2DatOe[0]) p1drv = 1; end
    join
    chk("R5 inhibit length", (inh >= INH && inh <= INH + 1), 1);
    chk("R5 tx data", got[7:0], 8'h5A);
    chk("R5 tx parity", got[8], ~^8'h5A);
    chk("R5 tx stop", got[9], 1'b1);
    chk("R5 other port idle", p1drv, 0);
    rd(3'd1, v); chk("R5 sent flag", v[3:0], 4'h2);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_tx_noack;
    logic [7:0] v;
    logic [9:0] got;
    int inh;
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hC1);
    devRecv(0, 0, 11, got, inh);
    chk("R7 tx data port1", got[7:0], 8'hC1);
    rd(3'd1, v); chk("R7 noack flags", v[3:0], 4'h4);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_tx_start_tmo;
    logic [7:0] v;
    wr(3'd3, 8'h42);
    cyc(INH + STO + 30);
    rd(3'd1, v); chk("R6 start timeout", v[3:0], 4'h4);
    rd(3'd6, v); chk("R6 released", v, 8'h0F);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_tx_finish_tmo;
    logic [7:0] v;
    logic [9:0] got;
    int inh;
    wr(3'd3, 8'h99);
    devRecv(0, 0, 3, got, inh);
    cyc(FTO);
    rd(3'd1, v); chk("R6 finish timeout", v[3:0], 4'h4);
    rd(3'd6, v); chk("R6 released after abort", v, 8'h0F);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_rx_tmo;
    logic [7:0] v;
    sendFrame(0, 8'hFF, 0, 4);
    cyc(RTO + 100);
    rd(3'd2, v); chk("R8 rx timeout flag", v[1], 1'b1);
    rd(3'd1, v); chk("R8 no rx event", v[0], 1'b0);
    sendFrame(0, 8'h77, 0, 11);
    rd(3'd3, v); chk("R8 recovered byte", v, 8'h77);
    wr(3'd2, 8'h02);
    rd(3'd2, v); chk("R8 flag w1c", v[1], 1'b0);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_force_rx;
    logic [7:0] v;
    sendFrame(0, 8'h00, 0, 4);
    wr(3'd2, 8'h04);
    sendFrame(0, 8'hC3, 0, 11);
    rd(3'd3, v); chk("R9 rx reset byte", v, 8'hC3);
    rd(3'd1, v); chk("R9 rx reset flags", v[3:0], 4'h1);
    rd(3'd2, v); chk("R9 no rx timeout", v[1], 1'b0);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_force_tx;
    logic [7:0] v;
    wr(3'd3, 8'h24);
    cyc(10);
    chk("R9 tx holding clock", ps2ClkOe[0], 1'b1);
    wr(3'd2, 8'h08);
    rd(3'd6, v); chk("R9 tx reset released", v, 8'h0F);
    cyc(STO + INH + 50);
    rd(3'd1, v); chk("R9 no timeout after tx reset", v[3:0], 4'h0);
  endtask

  // pulse data line of port 1 low for len cycles, report whether pin register saw it
  task automatic glitch(input int len, output bit seen);
    seen = 0;
    @(negedge clk);
    regAddr = 3'd5;
    for (int i = 0; i < len + 20; i++) begin
      devDat[0] = (i < len) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (!regRdata[1]) seen = 1;
    end
    devDat[0] = 1'b1;
  endtask

  task automatic t_filter;
    bit s;
    wr(3'd4, 8'h00);
    glitch(2, s);  chk("R10 short filter drops 2", s, 0);
    glitch(6, s);  chk("R10 short filter passes 6", s, 1);
    wr(3'd4, 8'h01);
    glitch(6, s);  chk("R10 long filter drops 6", s, 0);
    glitch(12, s); chk("R10 long filter passes 12", s, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_rx_port1();
    t_rx_port2_par();
    t_rx_disabled();
    t_tx_ok();
    t_tx_noack();
    t_tx_start_tmo();
    t_tx_finish_tmo();
    t_rx_tmo();
    t_force_rx();
    t_force_tx();
    t_filter();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule